// File: doc/BRIEF.md
# Multi-Lane Byte Merger

This block sits behind one to four independent serial receive lanes. A transmitter has dealt the bytes of a packet out across these lanes in rotation. The block rebuilds the original single byte stream. Each lane arrives already deserialized. It carries a byte-valid strobe and its own start and end pulses. The lanes may be skewed against one another by a few cycles, and they may close the packet at different byte counts.

Each lane writes into a small FIFO of its own. A round-robin read pointer pulls one byte per cycle from the lanes in the order they were dealt. The first byte of a packet is marked, and so is the last. The last byte is known once the lane that would carry the following byte has closed and holds nothing more. Lanes above the configured count are masked completely. When a lane FIFO is written while full, the byte is dropped and an error flag is raised and held.

Top module: `lane_byte_merger`

## Requirements
- R1: `laneCount` selects the number of active lanes: the values 0, 1, 2 and 3 mean 1, 2, 3 and 4 lanes.
- R2: The transmitter places packet byte n on lane (n mod lanes). The merged output delivers the packet bytes in their original order, with no loss and no duplicates, provided no FIFO overflows.
- R3: Lane skew is absorbed by per-lane FIFOs of `FIFO_DEPTH` entries. No byte is emitted while the lane due next holds nothing, so a packet starts only once lane 0 has a byte.
- R4: `outSop` and `outEop` are asserted only together with `outValid`. `outSop` marks the first byte emitted after reset or after an `outEop`. `outEop` marks exactly one byte per packet.
- R5: A byte is flagged `outEop` when the lane that would carry the next byte has signalled end-of-transmission and its FIFO is empty. Lanes that close one byte short, or that carry no byte at all, still complete the packet.
- R6: Valid, start and end inputs on lanes at or above the active count have no effect on the output.
- R7: A write into a full lane FIFO with no read of that lane in the same cycle drops the byte and sets `overflowErr`. The flag stays set until reset.
- R8: During and right after reset, `outValid`, `outSop`, `outEop` and `overflowErr` are low.
- R9: With a single lane, a byte is not released as non-final until either a further byte is queued or the lane's end pulse is seen. The last byte is flagged only after that end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| laneCount | input | 2 | Active lanes minus one |
| laneValid | input | 4 | Per-lane byte strobe |
| laneData | input | 32 | Per-lane byte, lane g in bits [8g+7:8g] |
| laneSot | input | 4 | Per-lane start-of-transmission pulse |
| laneEot | input | 4 | Per-lane end-of-transmission pulse, with or after the lane's last byte |
| outValid | output | 1 | Merged byte valid |
| outData | output | 8 | Merged byte |
| outSop | output | 1 | First byte of packet |
| outEop | output | 1 | Last byte of packet |
| overflowErr | output | 1 | Sticky lane FIFO overflow |

## Verification
The hardest case to reach from the ports is a lane that holds the next byte while lane 0, or the lane due next, has not yet delivered. A related case is the packet end, where the final lane's end pulse lags its last byte or that lane carries nothing at all. The stimulus schedules every lane separately, with its own start offset and its own delay from last byte to end pulse. Packet lengths are chosen that do not divide by the lane count, plus a two-byte packet over four lanes. A behavioural queue model runs alongside and is compared on every clock, and each packet is also compared end to end against the bytes sent. A final back-to-back burst on all four lanes drives the FIFOs into overflow.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  localparam int unsigned MAX_LANES = 4;
  localparam int unsigned LANE_W    = $clog2(MAX_LANES);

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic              pop;
    logic [LANE_W-1:0] lane;
    logic              sop;
    logic              eop;
  } ctrl_t;
endpackage

// File: rtl/lbm_datapath.sv
module lbm_datapath
  import lbm_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned FIFO_DEPTH = 4,
  localparam int unsigned PTR_W     = $clog2(FIFO_DEPTH),
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [MAX_LANES-1:0]        activeMask,
  input  logic [MAX_LANES-1:0]        laneValid,
  input  logic [MAX_LANES*DATA_W-1:0] laneData,
  input  logic [MAX_LANES-1:0]        laneSot,
  input  logic [MAX_LANES-1:0]        laneEot,
  input  ctrl_t                       ctrl,
  output logic [CNT_W-1:0]            laneCnt [MAX_LANES],
  output logic [MAX_LANES-1:0]        laneDone,
  output logic                        outValid,
  output logic [DATA_W-1:0]           outData,
  output logic                        outSop,
  output logic                        outEop,
  output logic                        overflowErr
);

  logic [DATA_W-1:0]    headData [MAX_LANES];
  logic [MAX_LANES-1:0] ovfHit;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar g = 0; g < MAX_LANES; g++) begin : gLane
    logic [DATA_W-1:0] mem [FIFO_DEPTH];
    logic [PTR_W-1:0]  wrPtr, rdPtr;
    logic [CNT_W-1:0]  cnt;
    logic pushReq, popReq, full, doPush;

    assign pushReq   = laneValid[g] & activeMask[g];
    assign popReq    = ctrl.pop && (ctrl.lane == LANE_W'(g));
    assign full      = (cnt == CNT_W'(FIFO_DEPTH));
    assign doPush    = pushReq && (!full || popReq);
    assign ovfHit[g] = pushReq && full && !popReq;

    always_ff @(posedge clk) begin
      if (doPush) mem[wrPtr] <= laneData[g*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        cnt   <= '0;
      end else begin
        if (doPush) wrPtr <= bumpPtr(wrPtr);
        if (popReq) rdPtr <= bumpPtr(rdPtr);
        case ({doPush, popReq})
          2'b10:   cnt <= cnt + CNT_W'(1);
          2'b01:   cnt <= cnt - CNT_W'(1);
          default: cnt <= cnt;
        endcase
      end
    end

    // lane closed for this packet; reopened by the merged end or a new start
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) laneDone[g] <= 1'b0;
      else if (laneEot[g] && activeMask[g]) laneDone[g] <= 1'b1;
      else if (ctrl.eop || (laneSot[g] && activeMask[g])) laneDone[g] <= 1'b0;
    end

    assign headData[g] = mem[rdPtr];
    assign laneCnt[g]  = cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outData     <= '0;
      outSop      <= 1'b0;
      outEop      <= 1'b0;
      overflowErr <= 1'b0;
    end else begin
      outValid <= ctrl.pop;
      outSop   <= ctrl.pop && ctrl.sop;
      outEop   <= ctrl.pop && ctrl.eop;
      if (ctrl.pop) outData <= headData[ctrl.lane];
      if (|ovfHit) overflowErr <= 1'b1;
    end
  end

endmodule

// File: rtl/lbm_control.sv
module lbm_control
  import lbm_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LANE_W-1:0]    laneCount,
  input  logic [CNT_W-1:0]     laneCnt [MAX_LANES],
  input  logic [MAX_LANES-1:0] laneDone,
  output ctrl_t                ctrl
);

  logic [LANE_W-1:0] rrLane, nextLane;
  logic              sopArmed;
  logic [CNT_W-1:0]  needCnt, curCnt, nextCnt;
  logic              knownNext, lastByte, popNow;

  assign nextLane  = (rrLane >= laneCount) ? '0 : rrLane + LANE_W'(1);
  // with one lane the next byte comes from the same FIFO, behind the head
  assign needCnt   = (nextLane == rrLane) ? CNT_W'(1) : '0;
  assign curCnt    = laneCnt[rrLane];
  assign nextCnt   = laneCnt[nextLane];
  assign knownNext = laneDone[nextLane] || (nextCnt > needCnt);
  assign lastByte  = laneDone[nextLane] && (nextCnt == needCnt);
  assign popNow    = (curCnt != '0) && knownNext;

  always_comb begin
    ctrl.pop  = popNow;
    ctrl.lane = rrLane;
    ctrl.sop  = sopArmed;
    ctrl.eop  = popNow && lastByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrLane   <= '0;
      sopArmed <= 1'b1;
    end else if (popNow) begin
      rrLane   <= lastByte ? '0 : nextLane;
      sopArmed <= lastByte;
    end
  end

endmodule

// File: rtl/lane_byte_merger.sv
module lane_byte_merger
  import lbm_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned FIFO_DEPTH = 4,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [LANE_W-1:0]           laneCount,
  input  logic [MAX_LANES-1:0]        laneValid,
  input  logic [MAX_LANES*DATA_W-1:0] laneData,
  input  logic [MAX_LANES-1:0]        laneSot,
  input  logic [MAX_LANES-1:0]        laneEot,
  output logic                        outValid,
  output logic [DATA_W-1:0]           outData,
  output logic                        outSop,
  output logic                        outEop,
  output logic                        overflowErr
);

  ctrl_t                ctrl;
  logic [CNT_W-1:0]     laneCnt [MAX_LANES];
  logic [MAX_LANES-1:0] laneDone;
  logic [MAX_LANES-1:0] activeMask;

  for (genvar g = 0; g < MAX_LANES; g++) begin : gMask
    assign activeMask[g] = (LANE_W'(g) <= laneCount);
  end

  lbm_control #(.FIFO_DEPTH(FIFO_DEPTH)) u_control (
    .clk(clk), .rstN(rstN), .laneCount(laneCount),
    .laneCnt(laneCnt), .laneDone(laneDone), .ctrl(ctrl)
  );

  lbm_datapath #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) u_datapath (
    .clk(clk), .rstN(rstN), .activeMask(activeMask),
    .laneValid(laneValid), .laneData(laneData),
    .laneSot(laneSot), .laneEot(laneEot), .ctrl(ctrl),
    .laneCnt(laneCnt), .laneDone(laneDone),
    .outValid(outValid), .outData(outData), .outSop(outSop),
    .outEop(outEop), .overflowErr(overflowErr)
  );

endmodule

// File: rtl/lbm_checker.sv
module lbm_checker
  import lbm_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [MAX_LANES-1:0] laneValid,
  input logic                 outValid,
  input logic                 outSop,
  input logic                 outEop,
  input logic                 overflowErr
);

  AST_SOP_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    outSop |-> outValid); // R4

  AST_EOP_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    outEop |-> outValid); // R4

  AST_START_AFTER_END: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outEop) |=> (!outValid || outSop)); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr); // R7

  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflowErr) |-> $past(|laneValid)); // R7

endmodule

bind lane_byte_merger lbm_checker u_checker (
  .clk(clk), .rstN(rstN), .laneValid(laneValid), .outValid(outValid),
  .outSop(outSop), .outEop(outEop), .overflowErr(overflowErr)
);

// File: tb/lane_byte_merger_bench.sv
module lane_byte_merger_bench;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  laneCount = 2'd3;
  logic [3:0]  laneValid = '0;
  logic [31:0] laneData = '0;
  logic [3:0]  laneSot = '0;
  logic [3:0]  laneEot = '0;
  logic        outValid, outSop, outEop, overflowErr;
  logic [7:0]  outData;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  lane_byte_merger u_lane_byte_merger (
    .clk(clk), .rstN(rstN), .laneCount(laneCount), .laneValid(laneValid),
    .laneData(laneData), .laneSot(laneSot), .laneEot(laneEot),
    .outValid(outValid), .outData(outData), .outSop(outSop),
    .outEop(outEop), .overflowErr(overflowErr)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: queues per lane, closed flags, read pointer
  logic [7:0] mq [4][$];
  bit   md [4];
  int   mrr;
  bit   mArm;
  bit   eValid, eSop, eEop, eErr;
  logic [7:0] eData;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int g = 0; g < 4; g++) begin mq[g].delete(); md[g] = 0; end
      mrr = 0; mArm = 1; eValid = 0; eSop = 0; eEop = 0; eErr = 0; eData = 0;
    end else begin
      int n, nx, need;
      bit known, last;
      n = int'(laneCount) + 1;
      nx = (mrr + 1) % n;
      need = (nx == mrr) ? 1 : 0;
      known = md[nx] || (mq[nx].size() > need);
      last = md[nx] && (mq[nx].size() == need);
      if (mq[mrr].size() > 0 && known) begin
        eValid = 1; eData = mq[mrr].pop_front(); eSop = mArm; eEop = last;
        mArm = last;
        mrr = last ? 0 : nx;
        if (last) for (int g = 0; g < 4; g++) md[g] = 0;
      end else begin
        eValid = 0; eSop = 0; eEop = 0;
      end
      for (int g = 0; g < n; g++) begin
        if (laneSot[g]) md[g] = 0;
        if (laneEot[g]) md[g] = 1;
        if (laneValid[g]) begin
          if (mq[g].size() >= DEPTH) eErr = 1;
          else mq[g].push_back(laneData[g*8 +: 8]);
        end
      end
    end
  end

  logic [7:0] got [$];
  int eopSeen = 0;

  always @(negedge clk) begin
    if (rstN) begin
      chk(outValid == eValid, "R3 outValid", int'(outValid), int'(eValid));
      chk({outSop, outEop} == {eSop, eEop}, "R4 sop/eop", int'({outSop, outEop}), int'({eSop, eEop}));
      if (eValid) chk(outData == eData, "R2 outData", int'(outData), int'(eData));
      chk(overflowErr == eErr, "R7 overflowErr", int'(overflowErr), int'(eErr));
      if (outValid) begin
        got.push_back(outData);
        if (outEop) eopSeen++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog R5 actual=%0d expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // lane g carries bytes g, g+n, ... starting at cycle sk[g], one every gap cycles
  task automatic sendPacket(input int n, input int len, input int sk[4], input int eotLate,
                            input int gap, input logic [7:0] base, input bit waitEnd, input string tag);
    int cnt[4];
    int eotT[4];
    int total = 0;
    laneCount = 2'(n - 1);
    got.delete();
    eopSeen = 0;
    for (int g = 0; g < 4; g++) begin
      cnt[g] = (g < n && len > g) ? (len - g + n - 1) / n : 0;
      eotT[g] = (cnt[g] > 0) ? sk[g] + (cnt[g] - 1) * gap + eotLate : sk[g] + eotLate;
      if (eotT[g] > total) total = eotT[g];
    end
    for (int t = 0; t <= total; t++) begin
      @(negedge clk);
      for (int g = 0; g < 4; g++) begin
        if (g < n) begin
          int k;
          k = (t >= sk[g]) ? (t - sk[g]) / gap : -1;
          laneValid[g] = (t >= sk[g]) && ((t - sk[g]) % gap == 0) && (k < cnt[g]);
          laneData[g*8 +: 8] = base + 8'(g + k * n);
          laneSot[g] = (t == sk[g]);
          laneEot[g] = (t == eotT[g]);
        end else begin
          laneValid[g] = 1'b1;           // junk on masked lanes (R6)
          laneData[g*8 +: 8] = 8'hEE;
          laneSot[g] = t[0];
          laneEot[g] = ~t[0];
        end
      end
    end
    @(negedge clk);
    laneValid = '0; laneSot = '0; laneEot = '0; laneData = '0;
    if (waitEnd) begin
      for (int w = 0; w < 300 && eopSeen == 0; w++) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(got.size() == len, {tag, " R2 byte count"}, got.size(), len);
      for (int i = 0; i < len && i < got.size(); i++)
        chk(got[i] == base + 8'(i), {tag, " R2 order"}, int'(got[i]), int'(base + 8'(i)));
      chk(eopSeen == 1, {tag, " R5 single end"}, eopSeen, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({outValid, outSop, outEop, overflowErr} == 4'b0, "R8 reset", int'({outValid, outSop, outEop, overflowErr}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({outValid, overflowErr} == 2'b0, "R8 after reset", int'({outValid, overflowErr}), 0);

    sendPacket(4, 16, '{0, 0, 0, 0}, 0, 4, 8'h10, 1, "R1 four lanes even");
    sendPacket(4, 13, '{3, 0, 1, 2}, 0, 4, 8'h40, 1, "R3 lane0 late uneven");
    sendPacket(3, 10, '{0, 2, 1, 0}, 2, 3, 8'h70, 1, "R5 late end three lanes");
    sendPacket(2, 7, '{1, 0, 0, 0}, 1, 2, 8'hA0, 1, "R6 masked junk two lanes");
    sendPacket(1, 5, '{0, 0, 0, 0}, 4, 1, 8'hC0, 1, "R9 single lane late end");
    sendPacket(4, 2, '{0, 1, 2, 3}, 1, 4, 8'hD0, 1, "R5 empty lanes");
    sendPacket(4, 9, '{2, 2, 0, 1}, 0, 4, 8'h55, 1, "R2 skewed again");

    sendPacket(4, 40, '{0, 0, 0, 0}, 0, 1, 8'h00, 0, "R7 burst");
    repeat (60) @(negedge clk);
    chk(overflowErr == 1'b1, "R7 flag set", int'(overflowErr), 1);
    repeat (20) @(negedge clk);
    chk(overflowErr == 1'b1, "R7 flag held", int'(overflowErr), 1);
    rstN = 1'b0;
    @(negedge clk);
    chk(overflowErr == 1'b0, "R7 cleared by reset", int'(overflowErr), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    sendPacket(2, 6, '{0, 1, 0, 0}, 0, 2, 8'h30, 1, "R1 after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule